// File: doc/BRIEF.md
# External Bus Handover Arbiter

This block decides when the processor core gives its external address bus, data bus and memory strobes to an outside master. The outside master pulls an active-low request pin, `br_n`, low. The block passes that pin through a synchroniser. Once no external transfer is running, the block switches off every driver the core owns on the external bus and pulls the grant pin `bg_n` low. When the outside master lets go of the request, the block ends the grant. It then waits one further cycle before turning the core's drivers back on, so the two masters never drive the bus in the same cycle.

Two conditions hold the handover back. The first is `ext_busy`, which the memory interface raises for an external access or a boot byte that is still in flight. The second is the core's own request for an external access. That request arrives as a valid/ready pair. `acc_valid` must stay high, with the access unchanged, until the cycle in which `acc_ready` is high; the access is issued in that cycle. While the bus is away, `acc_ready` stays low, so the access waits and goes out once the bus has been won back. `core_halt` tells the core to stop. In normal mode it stays high for as long as the core does not own the bus. In go mode it rises only while the core has an external access waiting for the bus.

Top module: `bus_hold_arbiter`

## Requirements
- R1: `br_n` passes through two flip-flops before the block acts on it. If `br_n` is low before rising edge k, and `ext_busy` is low, the grant (`bg_n` = 0) appears after edge k+2.
- R2: While `bg_n` is 0 (0 means granted), `addr_oe` and `data_oe` are 0, and all five bits of `strobe_oe` are 0. Bits 0 to 4 enable the program-select, data-select, boot-select, read and write drivers.
- R3: A synchronised request that arrives while `ext_busy` is 1 is deferred. `bg_n` falls on the first edge at which `ext_busy` is sampled 0.
- R4: If `br_n` is high before edge k, `bg_n` returns to 1 after edge k+2. The drivers stay off for that cycle and come back on (all enables 1) after edge k+3.
- R5: With `go_mode` = 0, `core_halt` is 1 in every cycle in which the drivers are off, and 0 otherwise.
- R6: With `go_mode` = 1, `core_halt` is 1 only when the drivers are off and `acc_valid` is 1.
- R7: `acc_ready` is 1 only when the core owns the bus (drivers on, `bg_n` = 1). An access that waits through a grant completes in the first cycle after the drivers come back on.
- R8: When the synchronised request is active, `ext_busy` is 0 and the core owns the bus, the outside request wins. `acc_ready` is 0 in that cycle even if `acc_valid` is 1.
- R9: After reset, `bg_n` is 1, all enables are 1, `core_halt` is 0, and the synchroniser holds "no request".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_n | input | 1 | Outside master's bus request, active low, asynchronous |
| go_mode | input | 1 | 1 lets the core run during a grant until it needs the external bus |
| ext_busy | input | 1 | An external access or boot byte is in flight |
| acc_valid | input | 1 | The core has an external access to issue |
| acc_ready | output | 1 | The access is issued in this cycle |
| bg_n | output | 1 | Bus grant, active low |
| addr_oe | output | 1 | Address bus driver enable |
| data_oe | output | 1 | Data bus driver enable |
| strobe_oe | output | 5 | Strobe driver enables: program select, data select, boot select, read, write |
| core_halt | output | 1 | Core must stall |

## Verification
The bench uses held request pulses of random length together with random `ext_busy` activity. This separates the plain grant path from the deferred path, and it tests release timing across short and long grants. The core's access stream follows the valid/ready rules and sometimes collides with a request in the same cycle. That shows whether the outside master wins the collision, and whether a waiting access is kept and then issued after release. `go_mode` is run both ways over the same patterns, which tells the full halt apart from the stall that only happens when the core needs the bus. Directed runs pin down the exact edge counts for grant, deferral and release.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [1:0] {
    OWNED   = 2'd0,
    LENT    = 2'd1,
    RECLAIM = 2'd2
  } hold_state_t;
endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic req_sync_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= req_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign req_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import bus_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_s,
  input  logic        ext_busy,
  output hold_state_t state_o,
  output logic        grant_pending_o
);
  hold_state_t state_q, state_d;

  assign grant_pending_o = (state_q == OWNED) && req_s && !ext_busy;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OWNED:   if (grant_pending_o) state_d = LENT;
      LENT:    if (!req_s)          state_d = RECLAIM;
      RECLAIM:                      state_d = OWNED;
      default:                      state_d = OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= OWNED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R1: a grant only follows a synchronised request
  assert_grant_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LENT && $past(state_q) == OWNED) |-> $past(req_s));
  // R4: the lent state always passes through reclaim
  assert_lent_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == LENT && state_q != LENT) |-> state_q == RECLAIM);
endmodule

// File: rtl/drive_ctl.sv
module drive_ctl
  import bus_hold_pkg::*;
#(
  parameter int NUM_STROBES = 5
) (
  input  hold_state_t            state_i,
  input  logic                   go_mode,
  input  logic                   acc_valid,
  input  logic                   grant_pending,
  output logic                   bg_n,
  output logic                   addr_oe,
  output logic                   data_oe,
  output logic [NUM_STROBES-1:0] strobe_oe,
  output logic                   core_halt,
  output logic                   acc_ready
);
  logic owned;
  assign owned   = (state_i == OWNED);
  assign bg_n    = (state_i != LENT);
  assign addr_oe = owned;
  assign data_oe = owned;

  genvar g;
  generate
    for (g = 0; g < NUM_STROBES; g++) begin : g_strobe
      assign strobe_oe[g] = owned;
    end
  endgenerate

  assign core_halt = go_mode ? (!owned && acc_valid) : !owned;
  assign acc_ready = owned && !grant_pending;
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bus_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_STROBES = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   br_n,
  input  logic                   go_mode,
  input  logic                   ext_busy,
  input  logic                   acc_valid,
  output logic                   acc_ready,
  output logic                   bg_n,
  output logic                   addr_oe,
  output logic                   data_oe,
  output logic [NUM_STROBES-1:0] strobe_oe,
  output logic                   core_halt
);
  logic        req_s;
  logic        pending;
  hold_state_t state;

  req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_async(!br_n), .req_sync_o(req_s)
  );

  hold_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .ext_busy(ext_busy),
    .state_o(state), .grant_pending_o(pending)
  );

  drive_ctl #(.NUM_STROBES(NUM_STROBES)) u_drv (
    .state_i(state), .go_mode(go_mode), .acc_valid(acc_valid),
    .grant_pending(pending), .bg_n(bg_n), .addr_oe(addr_oe),
    .data_oe(data_oe), .strobe_oe(strobe_oe), .core_halt(core_halt),
    .acc_ready(acc_ready)
  );

  assert_drivers_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bg_n |-> (!addr_oe && !data_oe && strobe_oe == '0));
  assert_defer_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bg_n) |-> !$past(ext_busy));
  assert_reclaim_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe) |-> ($past(bg_n) && bg_n));
  assert_halt_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_mode && !addr_oe) |-> core_halt);
  assert_go_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go_mode && !acc_valid) |-> !core_halt);
  assert_ready_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> (bg_n && addr_oe && data_oe));
  assert_enables_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_oe == '0) || (&strobe_oe));
endmodule

// File: tb/bus_hold_arbiter_tb.sv
module bus_hold_arbiter_tb_top;
  localparam int NS = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic br_n = 1'b1, go_mode = 1'b0, ext_busy = 1'b0, acc_valid = 1'b0;
  logic acc_ready, bg_n, addr_oe, data_oe, core_halt;
  logic [NS-1:0] strobe_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  // expected-state encoding: 0 owned, 1 granted, 2 drivers still off after release
  int m_st = 0;
  bit m_s1 = 0, m_s2 = 0;

  always #4 clk = ~clk;

  bus_hold_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .br_n(br_n), .go_mode(go_mode), .ext_busy(ext_busy),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .bg_n(bg_n), .addr_oe(addr_oe),
    .data_oe(data_oe), .strobe_oe(strobe_oe), .core_halt(core_halt)
  );

  function automatic bit f_ready(int st, bit s2, bit busy);
    return (st == 0) && !(s2 && !busy);
  endfunction
  function automatic bit f_halt(int st, bit go, bit v);
    return go ? (st != 0 && v) : (st != 0);
  endfunction
  function automatic int f_next(int st, bit s2, bit busy);
    if (st == 0) return (s2 && !busy) ? 1 : 0;
    if (st == 1) return s2 ? 1 : 2;
    return 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1", "bg_n", bg_n, (m_st == 1) ? 0 : 1);
    chk("R4", "addr_oe", addr_oe, (m_st == 0) ? 1 : 0);
    chk("R2", "data_oe", data_oe, (m_st == 0) ? 1 : 0);
    chk("R2", "strobe_oe", strobe_oe, (m_st == 0) ? 5'h1f : 5'h00);
    chk(go_mode ? "R6" : "R5", "core_halt", core_halt, f_halt(m_st, go_mode, acc_valid));
    chk("R7", "acc_ready", acc_ready, f_ready(m_st, m_s2, ext_busy));
  endtask

  // one clock: advance the model at the edge, compare at the following falling edge
  task automatic cycle();
    @(posedge clk);
    m_st = f_next(m_st, m_s2, ext_busy);
    m_s2 = m_s1;
    m_s1 = !br_n;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset bg_n", bg_n, 1);
    chk("R9", "reset oe", {addr_oe, data_oe, strobe_oe}, 7'h7f);
    chk("R9", "reset halt", core_halt, 0);
    rst_n = 1'b1;
    cycle();

    // R1 grant after third edge
    br_n = 1'b0;
    cycle(); cycle();
    chk("R1", "no grant before sync", bg_n, 1);
    // R8 request wins over a same-cycle access
    acc_valid = 1'b1;
    #1 chk("R8", "ready while request wins", acc_ready, 0);
    cycle();
    chk("R1", "grant third edge", bg_n, 0);
    chk("R2", "drivers off", {addr_oe, data_oe, strobe_oe}, 0);
    chk("R5", "halt normal", core_halt, 1);
    go_mode = 1'b1;
    #1 chk("R6", "go mode access waiting", core_halt, 1);
    acc_valid = 1'b0;
    #1 chk("R6", "go mode no access", core_halt, 0);
    acc_valid = 1'b1; go_mode = 1'b0;
    cycle();
    // R4 release
    br_n = 1'b1;
    cycle(); cycle();
    chk("R4", "still granted", bg_n, 0);
    cycle();
    chk("R4", "grant ends", bg_n, 1);
    chk("R4", "gap drivers off", addr_oe, 0);
    chk("R7", "no ready in gap", acc_ready, 0);
    cycle();
    chk("R4", "drivers back", {addr_oe, data_oe, strobe_oe}, 7'h7f);
    chk("R7", "waiting access issued", acc_ready, 1);
    acc_valid = 1'b0;
    cycle();

    // R3 deferral behind an external transfer
    ext_busy = 1'b1; br_n = 1'b0;
    repeat (6) cycle();
    chk("R3", "deferred while busy", bg_n, 1);
    ext_busy = 1'b0;
    cycle();
    chk("R3", "grant after busy drops", bg_n, 0);
    br_n = 1'b1;
    repeat (5) cycle();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) br_n = ~br_n;
      ext_busy = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 63) == 0) go_mode = ~go_mode;
      if (!(acc_valid && !acc_ready)) acc_valid = ($urandom_range(0, 2) == 0);
      cycle();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule